// File: doc/BRIEF.md
# Next-PC Predictor with History-Selected Counters and Target Cache

The block sits beside instruction fetch. Each cycle it takes the fetch address and, in the same cycle, returns the address to fetch next. It makes that choice from two structures. The first is a table of 2-bit saturating direction counters. Its index is formed from the word-address bits of the PC, with a short global outcome history appended. The second is a direct-mapped target cache. Each entry holds a valid flag, the complete address of a branch and the destination that branch last jumped to.

When a branch resolves further down the pipeline, the core presents that branch on the resolve port. This carries the branch address, whether it was taken, where it went, and the history value that was current when the branch was predicted. The history value is returned to the core on a separate output for this purpose. A strobe marks the cycle as a real control-transfer resolve. On such a cycle the block trains the selected counter, shifts the outcome into the history, and records the destination in the target cache when the branch was taken. All updates become visible to fetch on the next clock edge.

Top module: `npc_predictor`

## Requirements
- R1: After reset the history is 0, every direction counter holds 1 (weakly not taken) and every target entry is invalid, so predTaken is 0 and predNextPc equals fetchPc+4.
- R2: On a resolve, the selected counter increments when the branch was taken and decrements when it was not, saturating at 3 and at 0. predTaken is 1 exactly when the fetched counter is 2 or 3, so a strongly biased counter needs two opposite outcomes before its prediction flips.
- R3: The fetch counter index is {fetchPc[IDX_W+1:2], predHist}. The resolve counter index is {resPc[IDX_W+1:2], resHist}, so the resolve port chooses the history value used for training.
- R4: Every cycle with resIsBranch high shifts resTaken into bit 0 of the history, and older bits move toward the MSB.
- R5: The target entry is selected by fetchPc[BTB_W+1:2]. It hits only when it is valid and its stored full address equals fetchPc, so a PC that aliases to the same entry misses.
- R6: predNextPc is the stored target when the target entry hits and predTaken is 1. Otherwise it is fetchPc+4.
- R7: Only a resolve with resTaken high writes the target entry (valid, resPc, resTarget). A not-taken resolve leaves the entry unchanged.
- R8: With resIsBranch low, the resolve inputs have no effect on the counters, the history or the target cache.
- R9: Updates from a resolve are visible to a fetch lookup in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchPc | input | PC_W | Address being fetched this cycle |
| predNextPc | output | PC_W | Predicted next fetch address |
| predTaken | output | 1 | Direction prediction for fetchPc |
| predHist | output | HIST_W | Current global history, to be returned on resolve |
| resIsBranch | input | 1 | Marks a valid control-transfer resolve this cycle |
| resPc | input | PC_W | Address of the resolving branch |
| resTaken | input | 1 | Actual outcome |
| resTarget | input | PC_W | Actual destination |
| resHist | input | HIST_W | History captured when the branch was predicted |

## Verification
The assertions assume that fetchPc and the resolve inputs are stable across each clock edge. They also assume that at most one resolve arrives per cycle, which the single port enforces. They do not assume any relationship between resHist and the current history. The bench drives word-aligned addresses drawn from a small pool that includes entries aliasing in the target cache. It usually returns the history it was given and sometimes returns an arbitrary one, so both training paths of R3 are exercised. While resIsBranch is low it leaves random values on the other resolve pins.

// File: rtl/npc_pred_pkg.sv
package npc_pred_pkg;
  // Update strobes passed from control to datapath
  typedef struct packed {
    logic cntUpd;    // train one direction counter
    logic cntUp;     // direction of training
    logic histShift; // shift outcome into global history
    logic btbWrite;  // record taken target
  } updStrobes_t;
endpackage

// File: rtl/npc_pred_ctrl.sv
module npc_pred_ctrl
  import npc_pred_pkg::*;
(
  input  logic        resIsBranch,
  input  logic        resTaken,
  output updStrobes_t strobes
);
  always_comb begin
    strobes.cntUpd    = resIsBranch;
    strobes.cntUp     = resTaken;
    strobes.histShift = resIsBranch;
    strobes.btbWrite  = resIsBranch && resTaken;
  end
endmodule

// File: rtl/npc_pred_dpath.sv
module npc_pred_dpath
  import npc_pred_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2,
  parameter int BTB_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  updStrobes_t       strobes,
  input  logic [PC_W-1:0]   fetchPc,
  input  logic [PC_W-1:0]   resPc,
  input  logic              resTaken,
  input  logic [PC_W-1:0]   resTarget,
  input  logic [HIST_W-1:0] resHist,
  output logic [PC_W-1:0]   predNextPc,
  output logic              predTaken,
  output logic [HIST_W-1:0] predHist
);
  localparam int TI_W  = IDX_W + HIST_W;
  localparam int CNT_N = 1 << TI_W;
  localparam int BTB_N = 1 << BTB_W;

  logic [1:0]        cntTab [CNT_N];
  logic              btbValid [BTB_N];
  logic [PC_W-1:0]   btbTag   [BTB_N];
  logic [PC_W-1:0]   btbTgt   [BTB_N];
  logic [HIST_W-1:0] ghr, ghrNext;

  logic [TI_W-1:0]  fIdx, rIdx;
  logic [BTB_W-1:0] fSlot, rSlot;
  logic             btbHit;

  assign fIdx  = {fetchPc[IDX_W+1:2], ghr};
  assign rIdx  = {resPc[IDX_W+1:2], resHist};
  assign fSlot = fetchPc[BTB_W+1:2];
  assign rSlot = resPc[BTB_W+1:2];

  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic up);
    if (up) return (cur == 2'd3) ? cur : cur + 2'd1;
    else    return (cur == 2'd0) ? cur : cur - 2'd1;
  endfunction

  // History shift variant picked by its width
  generate
    if (HIST_W == 1) begin : g_hist1
      assign ghrNext = resTaken;
    end else begin : g_histN
      assign ghrNext = {ghr[HIST_W-2:0], resTaken};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ghr <= '0;
      for (int i = 0; i < CNT_N; i++) cntTab[i] <= 2'd1;
    end else begin
      if (strobes.histShift) ghr <= ghrNext;
      if (strobes.cntUpd) cntTab[rIdx] <= satStep(cntTab[rIdx], strobes.cntUp);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < BTB_N; j++) begin
        btbValid[j] <= 1'b0;
        btbTag[j]   <= '0;
        btbTgt[j]   <= '0;
      end
    end else if (strobes.btbWrite) begin
      btbValid[rSlot] <= 1'b1;
      btbTag[rSlot]   <= resPc;
      btbTgt[rSlot]   <= resTarget;
    end
  end

  assign predTaken  = cntTab[fIdx][1];
  assign btbHit     = btbValid[fSlot] && (btbTag[fSlot] == fetchPc);
  assign predNextPc = (btbHit && predTaken) ? btbTgt[fSlot] : fetchPc + PC_W'(4);
  assign predHist   = ghr;
endmodule

// File: rtl/npc_predictor.sv
module npc_predictor
  import npc_pred_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 2,
  parameter int BTB_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   fetchPc,
  output logic [PC_W-1:0]   predNextPc,
  output logic              predTaken,
  output logic [HIST_W-1:0] predHist,
  input  logic              resIsBranch,
  input  logic [PC_W-1:0]   resPc,
  input  logic              resTaken,
  input  logic [PC_W-1:0]   resTarget,
  input  logic [HIST_W-1:0] resHist
);
  updStrobes_t strobes;

  npc_pred_ctrl u_ctrl (
    .resIsBranch(resIsBranch),
    .resTaken   (resTaken),
    .strobes    (strobes)
  );

  npc_pred_dpath #(
    .PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .BTB_W(BTB_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .fetchPc   (fetchPc),
    .resPc     (resPc),
    .resTaken  (resTaken),
    .resTarget (resTarget),
    .resHist   (resHist),
    .predNextPc(predNextPc),
    .predTaken (predTaken),
    .predHist  (predHist)
  );
endmodule

// File: rtl/npc_predictor_chk.sv
module npc_predictor_chk #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [PC_W-1:0]   fetchPc,
  input logic [PC_W-1:0]   predNextPc,
  input logic              predTaken,
  input logic [HIST_W-1:0] predHist,
  input logic              resIsBranch,
  input logic [PC_W-1:0]   resPc,
  input logic              resTaken,
  input logic [PC_W-1:0]   resTarget,
  input logic [HIST_W-1:0] resHist
);
  generate
    if (HIST_W > 1) begin : g_shift
      p_hist_shift_r4: assert property (@(posedge clk) disable iff (!rstN)
        resIsBranch |=> predHist == {$past(predHist[HIST_W-2:0]), $past(resTaken)});
    end
  endgenerate

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !resIsBranch |=> $stable(predHist));

  p_fallthrough_r6: assert property (@(posedge clk) disable iff (!rstN)
    !predTaken |-> predNextPc == fetchPc + PC_W'(4));

  p_taken_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resIsBranch && resTaken) |=>
      (fetchPc != $past(resPc) || !predTaken || predNextPc == $past(resTarget)));
endmodule

bind npc_predictor npc_predictor_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (.*);

// File: tb/npc_predictor_bench.sv
module npc_predictor_bench;
  localparam int PC_W = 32, IDX_W = 4, HIST_W = 2, BTB_W = 3;
  localparam int CNT_N = 1 << (IDX_W + HIST_W);
  localparam int BTB_N = 1 << BTB_W;

  logic clk = 0, rstN = 0;
  logic [PC_W-1:0] fetchPc = '0, predNextPc, resPc = '0, resTarget = '0;
  logic predTaken, resIsBranch = 0, resTaken = 0;
  logic [HIST_W-1:0] predHist, resHist = '0;

  npc_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .BTB_W(BTB_W)) u_npc_predictor (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predNextPc(predNextPc),
    .predTaken(predTaken), .predHist(predHist), .resIsBranch(resIsBranch),
    .resPc(resPc), .resTaken(resTaken), .resTarget(resTarget), .resHist(resHist));

  always #5 clk = ~clk;

  // reference model
  logic [1:0]        mCnt [CNT_N];
  logic              mValid [BTB_N];
  logic [PC_W-1:0]   mTag [BTB_N];
  logic [PC_W-1:0]   mTgt [BTB_N];
  logic [HIST_W-1:0] mHist;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [1:0] refSat(input logic [1:0] c, input logic up);
    if (up) return (c == 3) ? c : c + 1;
    return (c == 0) ? c : c - 1;
  endfunction

  task automatic chk(input string tag, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [PC_W-1:0] fpc, input logic isBr, input logic [PC_W-1:0] rpc,
                      input logic tk, input logic [PC_W-1:0] tgt, input logic [HIST_W-1:0] rh,
                      input string tag);
    logic [IDX_W+HIST_W-1:0] idx;
    logic [BTB_W-1:0] s;
    logic eTk, hit;
    @(negedge clk);
    fetchPc = fpc; resIsBranch = isBr; resPc = rpc; resTaken = tk; resTarget = tgt; resHist = rh;
    #1;
    idx = {fpc[IDX_W+1:2], mHist};
    s = fpc[BTB_W+1:2];
    eTk = mCnt[idx][1];
    hit = mValid[s] && (mTag[s] == fpc);
    chk({tag, " dir"}, PC_W'(predTaken), PC_W'(eTk));
    chk({tag, " npc"}, predNextPc, (hit && eTk) ? mTgt[s] : fpc + 4);
    chk({tag, " hist"}, PC_W'(predHist), PC_W'(mHist));
    @(posedge clk);
    if (isBr) begin
      mCnt[{rpc[IDX_W+1:2], rh}] = refSat(mCnt[{rpc[IDX_W+1:2], rh}], tk);
      mHist = {mHist[HIST_W-2:0], tk};
      if (tk) begin
        mValid[rpc[BTB_W+1:2]] = 1;
        mTag[rpc[BTB_W+1:2]] = rpc;
        mTgt[rpc[BTB_W+1:2]] = tgt;
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [PC_W-1:0] pool [8];
    logic [PC_W-1:0] pA, pB;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < CNT_N; i++) mCnt[i] = 1;
    for (int i = 0; i < BTB_N; i++) begin mValid[i] = 0; mTag[i] = 0; mTgt[i] = 0; end
    mHist = 0;
    pA = 32'h0000_0100; pB = 32'h0000_0204;
    repeat (3) @(posedge clk);
    rstN = 1;
    // R1: reset state
    step(pA, 0, 0, 0, 0, 0, "R1");
    step(pB, 0, 0, 0, 0, 0, "R1");
    // R2 R9: train pA taken with resHist 0, saturate
    repeat (4) step(pA, 1, pA, 1, 32'h0000_4000, 0, "R2 R9");
    // R4: bring history back to 00 via pB not-taken
    step(pA, 1, pB, 0, 32'h0, 2'd3, "R4");
    step(pA, 1, pB, 0, 32'h0, 2'd3, "R4");
    // R6: hit plus taken redirects
    step(pA, 0, 0, 0, 0, 0, "R6");
    // R2: one not-taken does not flip strong counter
    step(pA, 1, pA, 0, 32'h0000_7777, 0, "R2 R7");
    step(pA, 1, pB, 0, 0, 2'd1, "R2");
    step(pA, 1, pB, 0, 0, 2'd2, "R7");
    step(pA, 0, 0, 0, 0, 0, "R7");
    // R5: alias of pA in target slot misses
    step(pA + 32'h20, 0, 0, 0, 0, 0, "R5");
    // R8: idle with garbage on resolve pins
    for (int i = 0; i < 6; i++)
      step(pA, 0, $urandom, 1, $urandom, HIST_W'($urandom), "R8");
    step(pA, 0, 0, 0, 0, 0, "R8");
    // R3: resHist differs from current history
    step(pB, 1, pB, 1, 32'h0000_9000, 2'd2, "R3");
    step(pB, 1, pB, 1, 32'h0000_9000, 2'd2, "R3");
    step(pB, 0, 0, 0, 0, 0, "R3");
    // random mix
    for (int i = 0; i < 8; i++)
      pool[i] = 32'h0000_1000 + ((i % 4) << 2) + ((i / 4) << (BTB_W + 2));
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] rp;
      logic [HIST_W-1:0] rh;
      rp = pool[$urandom % 8];
      rh = ($urandom % 4 == 0) ? HIST_W'($urandom) : mHist;
      step(pool[$urandom % 8], ($urandom % 3) != 0, rp, $urandom % 4 != 0,
           32'h0001_0000 + ((PC_W'($urandom) % 64) << 2), rh, "R2 R3 R5 R6 R7");
    end
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule